// File: doc/BRIEF.md
# Overcurrent Fault Blanking Supervisor

This block is the digital fault controller of a high-side power switch. Two comparator outputs from the analog side tell it that the load current is above a low threshold or above a high threshold. The block measures how long each condition lasts against a timebase tick. When the output is on and the low-threshold condition lasts for a programmable blanking time, the block latches the switch off. The blanking time is chosen by a 2-bit code: 00 gives 155 ms, 01 gives 10 ms, 10 gives 1.2 ms and 11 gives 150 µs. The high-threshold condition has a fixed short trip time of at most 20 µs. This two-tier scheme behaves like a slow-blow fuse.

A disable input removes only the low-threshold timeout. The high-threshold trip always stays active. Once the block trips, the gate stays off until the output command goes low and then high again. The latched fault flag stays set through that low period so that status logic can read it. The block also turns the threshold select codes into ampere values for the analog comparators.

All times are parameters counted in ticks of tick_i. With a 1 µs tick, the default parameters give the times above.

Top module: `ocp_supervisor`

## Requirements
- R1: After reset, with cmd_i low, gate_en_o and fault_o are both 0.
- R2: While no fault is latched, gate_en_o equals cmd_i in the same cycle. gate_en_o is never 1 while cmd_i is 0.
- R3: The low-overcurrent timeout is counted in ticks.
  - blank_sel_i chooses the count: 00 gives BLANK_T0 (155 ms), 01 gives BLANK_T1 (10 ms), 10 gives BLANK_T2 (1.2 ms) and 11 gives BLANK_T3 (150 µs).
  - The count runs only while the output is on and lo_oc_i is held.
  - fault_o rises, and gate_en_o falls, on the clock edge after the cycle in which the completing tick is counted.
- R4: If lo_oc_i drops for at least one clock before the timeout, the low count restarts from zero.
- R5: While lo_tmo_dis_i is 1, a held lo_oc_i never latches a fault.
- R6: A held hi_oc_i latches a fault after HI_TICKS ticks (20 µs), with the same one-edge latency as in R3. This happens whatever the values of blank_sel_i and lo_tmo_dis_i.
- R7: Once a fault is latched:
  - gate_en_o stays 0 while cmd_i is held high, even after the overcurrent goes away.
  - fault_o stays 1 while cmd_i is low.
  - The latch clears on the first clock edge at which cmd_i is 1 after having been 0. gate_en_o then rises in the cycle that follows that edge.
- R8: lo_level_o equals 50 − 5·lo_sel_i amperes, as an unsigned 8-bit value: 000 gives 50 and 111 gives 15.
- R9: hi_level_o is 150 when hi_sel_i is 0 and 100 when hi_sel_i is 1.
- R10: While the output is off (cmd_i low), overcurrent inputs neither count nor latch a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase clock enable, one cycle per tick |
| cmd_i | input | 1 | Output on command |
| lo_oc_i | input | 1 | Low-threshold comparator output |
| hi_oc_i | input | 1 | High-threshold comparator output |
| lo_sel_i | input | 3 | Low threshold select code |
| hi_sel_i | input | 1 | High threshold select code |
| blank_sel_i | input | 2 | Low-overcurrent blanking time select |
| lo_tmo_dis_i | input | 1 | Disable low-overcurrent timeout |
| gate_en_o | output | 1 | Gate enable to the power stage |
| fault_o | output | 1 | Latched overcurrent fault |
| lo_level_o | output | 8 | Low threshold in amperes |
| hi_level_o | output | 8 | High threshold in amperes |

## Verification
The level outputs and the gate enable are combinational, so the bench checks them shortly after it changes an input.

A trip is due one clock edge after the edge that counts the final tick. The bench drives that final tick by itself. It checks that fault_o is still 0 and gate_en_o still 1 at the next falling edge, and that the fault has latched one falling edge later. One tick fewer than the full count must leave the fault clear.

Clearing the latch takes one edge after cmd_i rises. The bench therefore checks that gate_en_o is still 0 just after the rise and 1 one cycle later. All inputs change, and all outputs are sampled, on falling edges.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int unsigned BLANK_SEL_W = 2;
  localparam int unsigned NUM_TIERS   = 2;
  localparam int unsigned TIER_LO     = 0;
  localparam int unsigned TIER_HI     = 1;

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned lo_amps(int unsigned base, int unsigned step,
                                          int unsigned code);
    return base - step * code;
  endfunction
endpackage

// File: rtl/ocp_tick_timer.sv
module ocp_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // count saturates at the limit; any gap in run_i restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/ocp_blank_sel.sv
module ocp_blank_sel
  import ocp_pkg::*;
#(
  parameter int unsigned CNT_W = 18,
  parameter int unsigned T0    = 155000,
  parameter int unsigned T1    = 10000,
  parameter int unsigned T2    = 1200,
  parameter int unsigned T3    = 150
) (
  input  logic [BLANK_SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0]       limit_o
);
  always_comb begin
    case (sel_i)
      2'b00:   limit_o = CNT_W'(T0);
      2'b01:   limit_o = CNT_W'(T1);
      2'b10:   limit_o = CNT_W'(T2);
      default: limit_o = CNT_W'(T3);
    endcase
  end
endmodule

// File: rtl/ocp_level_enc.sv
module ocp_level_enc
  import ocp_pkg::*;
#(
  parameter int unsigned LO_SEL_W  = 3,
  parameter int unsigned LVL_W     = 8,
  parameter int unsigned LO_BASE_A = 50,
  parameter int unsigned LO_STEP_A = 5,
  parameter int unsigned HI_BASE_A = 150,
  parameter int unsigned HI_ALT_A  = 100
) (
  input  logic [LO_SEL_W-1:0] lo_sel_i,
  input  logic                hi_sel_i,
  output logic [LVL_W-1:0]    lo_level_o,
  output logic [LVL_W-1:0]    hi_level_o
);
  assign lo_level_o = LVL_W'(lo_amps(LO_BASE_A, LO_STEP_A, int'(lo_sel_i)));
  assign hi_level_o = hi_sel_i ? LVL_W'(HI_ALT_A) : LVL_W'(HI_BASE_A);
endmodule

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic trip_i,
  output logic latched_o
);
  logic cmd_q;
  logic rearm;

  assign rearm = cmd_i && !cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= 1'b0;
      latched_o <= 1'b0;
    end else begin
      cmd_q <= cmd_i;
      // a new trip wins over re-arming
      if (trip_i)     latched_o <= 1'b1;
      else if (rearm) latched_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ocp_supervisor.sv
module ocp_supervisor
  import ocp_pkg::*;
#(
  parameter int unsigned LO_SEL_W = 3,
  parameter int unsigned LVL_W    = 8,
  parameter int unsigned BLANK_T0 = 155000,
  parameter int unsigned BLANK_T1 = 10000,
  parameter int unsigned BLANK_T2 = 1200,
  parameter int unsigned BLANK_T3 = 150,
  parameter int unsigned HI_TICKS = 20
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   cmd_i,
  input  logic                   lo_oc_i,
  input  logic                   hi_oc_i,
  input  logic [LO_SEL_W-1:0]    lo_sel_i,
  input  logic                   hi_sel_i,
  input  logic [BLANK_SEL_W-1:0] blank_sel_i,
  input  logic                   lo_tmo_dis_i,
  output logic                   gate_en_o,
  output logic                   fault_o,
  output logic [LVL_W-1:0]       lo_level_o,
  output logic [LVL_W-1:0]       hi_level_o
);
  localparam int unsigned MAX_T = max_of(max_of(max_of(BLANK_T0, BLANK_T1),
                                                max_of(BLANK_T2, BLANK_T3)), HI_TICKS);
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic                 latched;
  logic                 armed;
  logic [NUM_TIERS-1:0] run;
  logic [NUM_TIERS-1:0] expire;
  logic [CNT_W-1:0]     limit [NUM_TIERS];

  assign armed = cmd_i && !latched;
  assign run[TIER_LO] = armed && lo_oc_i && !lo_tmo_dis_i;
  assign run[TIER_HI] = armed && hi_oc_i;
  assign limit[TIER_HI] = CNT_W'(HI_TICKS);

  ocp_blank_sel #(
    .CNT_W (CNT_W),
    .T0    (BLANK_T0),
    .T1    (BLANK_T1),
    .T2    (BLANK_T2),
    .T3    (BLANK_T3)
  ) u_blank (
    .sel_i   (blank_sel_i),
    .limit_o (limit[TIER_LO])
  );

  for (genvar g = 0; g < NUM_TIERS; g++) begin : g_tier
    ocp_tick_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run[g]),
      .tick_i   (tick_i),
      .limit_i  (limit[g]),
      .expire_o (expire[g])
    );
  end

  ocp_trip_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_i),
    .trip_i    (|expire),
    .latched_o (latched)
  );

  ocp_level_enc #(
    .LO_SEL_W (LO_SEL_W),
    .LVL_W    (LVL_W)
  ) u_lvl (
    .lo_sel_i   (lo_sel_i),
    .hi_sel_i   (hi_sel_i),
    .lo_level_o (lo_level_o),
    .hi_level_o (hi_level_o)
  );

  assign gate_en_o = armed;
  assign fault_o   = latched;
endmodule

// File: rtl/ocp_supervisor_chk.sv
module ocp_supervisor_chk #(
  parameter int unsigned LVL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_i,
  input logic             hi_oc_i,
  input logic             lo_tmo_dis_i,
  input logic             gate_en_o,
  input logic             fault_o,
  input logic [LVL_W-1:0] lo_level_o
);
  AST_GATE_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> cmd_i); // R2

  AST_FAULT_BLOCKS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !gate_en_o); // R7

  AST_FAULT_KEPT_WHILE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !cmd_i) |=> fault_o); // R7

  AST_NO_TRIP_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && !cmd_i) |=> !fault_o); // R10

  AST_DIS_NO_LO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && lo_tmo_dis_i && !hi_oc_i) |=> !fault_o); // R5

  AST_LO_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_level_o >= LVL_W'(15)) && (lo_level_o <= LVL_W'(50))); // R8
endmodule

bind ocp_supervisor ocp_supervisor_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_i        (cmd_i),
  .hi_oc_i      (hi_oc_i),
  .lo_tmo_dis_i (lo_tmo_dis_i),
  .gate_en_o    (gate_en_o),
  .fault_o      (fault_o),
  .lo_level_o   (lo_level_o)
);

// File: tb/sim_ocp_supervisor.sv
`timescale 1ns/1ps
module sim_ocp_supervisor;
  localparam int unsigned B0 = 40;
  localparam int unsigned B1 = 20;
  localparam int unsigned B2 = 12;
  localparam int unsigned B3 = 6;
  localparam int unsigned HT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cmd = 1'b0;
  logic       lo_oc = 1'b0;
  logic       hi_oc = 1'b0;
  logic [2:0] lo_sel = 3'd0;
  logic       hi_sel = 1'b0;
  logic [1:0] bsel = 2'd0;
  logic       dis = 1'b0;
  logic       gate;
  logic       fault;
  logic [7:0] lo_lvl;
  logic [7:0] hi_lvl;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ocp_supervisor #(
    .BLANK_T0 (B0), .BLANK_T1 (B1), .BLANK_T2 (B2), .BLANK_T3 (B3), .HI_TICKS (HT)
  ) u0 (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .cmd_i (cmd),
    .lo_oc_i (lo_oc), .hi_oc_i (hi_oc), .lo_sel_i (lo_sel), .hi_sel_i (hi_sel),
    .blank_sel_i (bsel), .lo_tmo_dis_i (dis),
    .gate_en_o (gate), .fault_o (fault), .lo_level_o (lo_lvl), .hi_level_o (hi_lvl)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  // no fault after n-1 ticks, none in the cycle after the n-th, latched one edge later
  task automatic trip_after(int n, string req);
    ticks(n - 1);
    chk({req, " no trip before count"}, fault, 0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk({req, " gate still on after last tick"}, gate, 1);
    chk({req, " fault not yet latched"}, fault, 0);
    @(negedge clk);
    chk({req, " fault latched"}, fault, 1);
    chk({req, " gate off"}, gate, 0);
  endtask

  task automatic recover();
    cmd = 1'b0;
    lo_oc = 1'b0;
    hi_oc = 1'b0;
    @(negedge clk);
    chk("R7 fault kept while cmd low", fault, 1);
    cmd = 1'b1;
    #1;
    chk("R7 gate off at cmd rise", gate, 0);
    @(negedge clk);
    chk("R7 fault cleared after rise", fault, 0);
    chk("R7 gate on after rise", gate, 1);
  endtask

  task automatic t_reset();
    chk("R1 gate after reset", gate, 0);
    chk("R1 fault after reset", fault, 0);
  endtask

  task automatic t_gate_follow();
    cmd = 1'b1;
    #1;
    chk("R2 gate follows cmd high", gate, 1);
    @(negedge clk);
    cmd = 1'b0;
    #1;
    chk("R2 gate follows cmd low", gate, 0);
    @(negedge clk);
  endtask

  task automatic t_levels();
    for (int c = 0; c < 8; c++) begin
      lo_sel = 3'(c);
      #1;
      chk($sformatf("R8 lo level code %0d", c), lo_lvl, 50 - 5 * c);
    end
    hi_sel = 1'b0;
    #1;
    chk("R9 hi level code 0", hi_lvl, 150);
    hi_sel = 1'b1;
    #1;
    chk("R9 hi level code 1", hi_lvl, 100);
    @(negedge clk);
  endtask

  task automatic t_blank(logic [1:0] code, int n);
    bsel = code;
    cmd = 1'b1;
    lo_oc = 1'b1;
    @(negedge clk);
    trip_after(n, $sformatf("R3 blank code %0d", code));
    lo_oc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 gate stays off with cmd held", gate, 0);
    chk("R7 fault stays with cmd held", fault, 1);
    recover();
  endtask

  task automatic t_restart();
    bsel = 2'b11;
    cmd = 1'b1;
    lo_oc = 1'b1;
    ticks(B3 - 2);
    lo_oc = 1'b0;
    @(negedge clk);
    lo_oc = 1'b1;
    trip_after(B3, "R4 restart after gap");
    recover();
  endtask

  task automatic t_disable();
    dis = 1'b1;
    bsel = 2'b00;
    cmd = 1'b1;
    lo_oc = 1'b1;
    ticks(B0 + 10);
    chk("R5 no trip with timeout disabled", fault, 0);
    chk("R5 gate on with timeout disabled", gate, 1);
    hi_oc = 1'b1;
    trip_after(HT, "R6 hi trip with disable set");
    recover();
    dis = 1'b0;
    bsel = 2'b00;
    hi_oc = 1'b1;
    trip_after(HT, "R6 hi trip slowest blank code");
    recover();
  endtask

  task automatic t_idle();
    cmd = 1'b0;
    lo_oc = 1'b1;
    hi_oc = 1'b1;
    bsel = 2'b11;
    ticks(B0 + 10);
    chk("R10 no fault while off", fault, 0);
    cmd = 1'b1;
    lo_oc = 1'b0;
    hi_oc = 1'b0;
    #1;
    chk("R10 gate on after idle overcurrent", gate, 1);
    @(negedge clk);
    chk("R10 no fault after switch on", fault, 0);
    cmd = 1'b1;
    lo_oc = 1'b1;
    trip_after(B3, "R10 count starts from zero at switch on");
    recover();
    cmd = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate_follow();
    t_levels();
    t_blank(2'b00, B0);
    t_blank(2'b01, B1);
    t_blank(2'b10, B2);
    t_blank(2'b11, B3);
    t_restart();
    t_disable();
    t_idle();
    summary();
    $finish;
  end
endmodule